// File: doc/BRIEF.md
# Cleaning Duration Setter and Countdown Timer

This block lets an operator dial in a cleaning duration of 0 to 999 minutes using four push buttons: confirm, initialise, up and down. The value is shown on three static seven-segment digits. Confirming a nonzero value starts a minute-by-minute countdown, and the digits then show the time that remains.

While the countdown runs, the block holds a run-enable flag high. The rest of the platform uses this flag to gate its motors. When the count reaches zero, the flag drops, a one-cycle completion pulse is issued, and the block goes back to setting mode with the previously chosen duration still loaded.

Each raw button line is synchronised and debounced before use, and only its press edge has an effect. The debounce window and the minute period are parameters derived from the 16 MHz system clock.

Top module: `clean_timer`

## Requirements
- R1: After reset `running` and `done` are low and the three digits show 000.
- R2: A button level is accepted only after it has been stable for `DEB_CYCLES` consecutive clocks. A shorter pulse has no effect. A press held for any length of time acts exactly once, on its press edge.
- R3: In setting mode an up press adds one to the set value, and 999 wraps to 000.
- R4: In setting mode a down press subtracts one from the set value, and 000 wraps to 999.
- R5: A confirm press in setting mode with a nonzero value raises `running`. The digits then show the remaining count, which starts at the set value.
- R6: A confirm press while the set value is 000 is ignored, and `running` stays low.
- R7: While running, the remaining count falls by one every `TICK_CYCLES` clocks after the start, with decimal borrow (for example 010 becomes 009).
- R8: On the clock where the count reaches 000, `running` falls and `done` is high for exactly that one cycle. The digits then return to the unchanged set value.
- R9: Up and down presses while running change neither the remaining count nor the set value.
- R10: An initialise press in any mode clears the set value to 000, drops `running`, returns to setting mode and raises no `done`.
- R11: Segment outputs are active high with bit order {g,f,e,d,c,b,a}. The digit codes 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| btn_ok | input | 1 | Raw confirm button, high when pressed |
| btn_init | input | 1 | Raw initialise button, high when pressed |
| btn_up | input | 1 | Raw increment button, high when pressed |
| btn_dn | input | 1 | Raw decrement button, high when pressed |
| seg_hund | output | 7 | Hundreds digit segments |
| seg_tens | output | 7 | Tens digit segments |
| seg_ones | output | 7 | Ones digit segments |
| running | output | 1 | Run enable, high while counting down |
| done | output | 1 | One-cycle pulse when the countdown expires |

## Verification
Setting is exercised with single presses across both wrap points. A glitch shorter than the debounce window shows whether filtering works, and a long hold shows whether the press edge acts only once. Countdowns from 2 and from 10 are compared against a reference on every clock. The run of 10 crosses a decimal borrow and walks the ones digit through all ten codes. Up and down presses injected during a run separate blocked from leaking controls. Confirm at 000 and initialise during a run cover the two ways a start or a run must end without a completion pulse.

// File: rtl/clean_tmr_pkg.sv
package clean_tmr_pkg;

    typedef enum logic {PH_SET, PH_RUN} phase_e;

    typedef logic [3:0] bcd_t;
    typedef bcd_t [2:0] bcd3_t;   // [2] hundreds, [1] tens, [0] ones

    function automatic bcd3_t bcd3_inc(bcd3_t v);
        bcd3_t r;
        logic  c;
        r = v;
        c = 1'b1;
        for (int i = 0; i < 3; i++) begin
            if (c) begin
                if (r[i] == 4'd9) begin
                    r[i] = 4'd0;
                end else begin
                    r[i] = r[i] + 4'd1;
                    c    = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic bcd3_t bcd3_dec(bcd3_t v);
        bcd3_t r;
        logic  b;
        r = v;
        b = 1'b1;
        for (int i = 0; i < 3; i++) begin
            if (b) begin
                if (r[i] == 4'd0) begin
                    r[i] = 4'd9;
                end else begin
                    r[i] = r[i] - 4'd1;
                    b    = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // active-high segments, {g,f,e,d,c,b,a}
    function automatic logic [6:0] seg_of(bcd_t d);
        logic [6:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/btn_press.sv
module btn_press #(
    parameter int DEB_CYCLES = 320000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic press
);
    localparam int DW = $clog2(DEB_CYCLES + 1);
    localparam logic [DW-1:0] DLAST = DW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          stable;
        logic [DW-1:0] cnt;
        logic          press;
    } st_t;

    st_t q, d;

    always_comb begin
        d       = q;
        d.s1    = raw;
        d.s2    = q.s1;
        d.press = 1'b0;
        if (q.s2 != q.stable) begin
            if (q.cnt == DLAST) begin
                d.stable = q.s2;
                d.cnt    = '0;
                d.press  = q.s2;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign press = q.press;

    // a held button yields one pulse only
    p_press_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.press |=> !q.press);

    p_press_needs_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.press |-> q.stable);

endmodule

// File: rtl/seg7_enc.sv
module seg7_enc
    import clean_tmr_pkg::*;
(
    input  bcd_t       digit,
    output logic [6:0] seg
);
    assign seg = seg_of(digit);
endmodule

// File: rtl/clean_timer.sv
module clean_timer
    import clean_tmr_pkg::*;
#(
    parameter int CLK_HZ      = 16000000,
    parameter int DEB_CYCLES  = CLK_HZ / 50,
    parameter int TICK_CYCLES = CLK_HZ * 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_ok,
    input  logic       btn_init,
    input  logic       btn_up,
    input  logic       btn_dn,
    output logic [6:0] seg_hund,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_ones,
    output logic       running,
    output logic       done
);
    localparam int NBTN = 4;
    localparam int TW   = $clog2(TICK_CYCLES);
    localparam logic [TW-1:0] TLAST = TW'(TICK_CYCLES - 1);

    typedef struct packed {
        phase_e        ph;
        bcd3_t         setv;
        bcd3_t         cnt;
        logic [TW-1:0] presc;
        logic          done;
    } st_t;

    st_t q, d;

    logic [NBTN-1:0] raw_v, prs;
    assign raw_v = {btn_dn, btn_up, btn_init, btn_ok};

    for (genvar g = 0; g < NBTN; g++) begin : g_btn
        btn_press #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[g]),
            .press(prs[g])
        );
    end

    logic  p_ok, p_init, p_up, p_dn;
    bcd3_t next_cnt;
    assign {p_dn, p_up, p_init, p_ok} = prs;
    assign next_cnt = bcd3_dec(q.cnt);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (p_init) begin
            d.ph    = PH_SET;
            d.setv  = '0;
            d.cnt   = '0;
            d.presc = '0;
        end else begin
            case (q.ph)
                PH_SET: begin
                    if (p_ok) begin
                        if (q.setv != '0) begin
                            d.ph    = PH_RUN;
                            d.cnt   = q.setv;
                            d.presc = '0;
                        end
                    end else if (p_up) begin
                        d.setv = bcd3_inc(q.setv);
                    end else if (p_dn) begin
                        d.setv = bcd3_dec(q.setv);
                    end
                end
                PH_RUN: begin
                    if (q.presc == TLAST) begin
                        d.presc = '0;
                        d.cnt   = next_cnt;
                        if (next_cnt == '0) begin
                            d.ph   = PH_SET;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.presc = q.presc + 1'b1;
                    end
                end
                default: d.ph = PH_SET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    bcd3_t show;
    assign show    = (q.ph == PH_RUN) ? q.cnt : q.setv;
    assign running = (q.ph == PH_RUN);
    assign done    = q.done;

    logic [2:0][6:0] segs;
    for (genvar g = 0; g < 3; g++) begin : g_seg
        seg7_enc u_seg (.digit(show[g]), .seg(segs[g]));
    end
    assign seg_hund = segs[2];
    assign seg_tens = segs[1];
    assign seg_ones = segs[0];

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    p_done_ends_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.ph == PH_SET && $past(q.ph) == PH_RUN && q.cnt == '0));

    p_start_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_RUN && $past(q.ph) == PH_SET) |-> q.cnt != '0);

    p_count_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_RUN && $past(q.ph) == PH_RUN) |-> (q.cnt <= $past(q.cnt) && $stable(q.setv)));

    p_digits_bcd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt[0] <= 4'd9 && q.cnt[1] <= 4'd9 && q.cnt[2] <= 4'd9));

endmodule

// File: tb/clean_timer_tb.sv
module clean_timer_tb;
    localparam int DEB  = 6;
    localparam int TICK = 40;
    localparam int HOLD = DEB + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] btn = '0;   // 0 ok, 1 init, 2 up, 3 dn
    logic [6:0] sh, st, so;
    logic running, done;

    int n_chk = 0, n_fail = 0, done_cnt = 0;
    int setv = 0;

    always #5 clk = ~clk;

    clean_timer #(.DEB_CYCLES(DEB), .TICK_CYCLES(TICK)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .btn_ok(btn[0]), .btn_init(btn[1]), .btn_up(btn[2]), .btn_dn(btn[3]),
        .seg_hund(sh), .seg_tens(st), .seg_ones(so),
        .running(running), .done(done)
    );

    always @(negedge clk) if (rst_n && done) done_cnt++;

    function automatic logic [6:0] enc(int dg);
        case (dg)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_disp(input int v, input string tag);
        logic [20:0] e, a;
        e = {enc(v / 100), enc((v / 10) % 10), enc(v % 10)};
        a = {sh, st, so};
        chk(a == e, tag, int'(a), int'(e));
    endtask

    task automatic press(input int b, input int len);
        @(negedge clk); btn[b] = 1'b1;
        repeat (len) @(negedge clk);
        btn[b] = 1'b0;
        repeat (HOLD) @(negedge clk);
    endtask

    // start a countdown and compare every clock; abort_k>0 ends early
    task automatic run_check(input bit poke, input int abort_k);
        int w, rem, k;
        @(negedge clk); btn[0] = 1'b1;
        w = 0;
        while (!running && w < 60) begin @(negedge clk); w++; end
        chk(running == 1'b1, "R5 running after confirm", int'(running), 1);
        chk_disp(setv, "R5 display at start");
        rem = setv;
        k = 0;
        while (1) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (k == HOLD) btn[0] = 1'b0;
            if (poke) begin
                btn[2] = (k >= 5  && k < 5 + HOLD);
                btn[3] = (k >= 20 && k < 20 + HOLD);
            end
            if (abort_k > 0 && k == abort_k) return;
            if (k % TICK == 0) rem--;
            if (rem == 0) begin
                chk(done == 1'b1, "R8 done at expiry", int'(done), 1);
                chk(running == 1'b0, "R8 running falls", int'(running), 0);
                chk_disp(setv, "R8 display back to set value");
                @(negedge clk);
                chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
                btn[2] = 1'b0; btn[3] = 1'b0;
                return;
            end
            chk(running == 1'b1 && done == 1'b0, "R7 running mid-count", int'(running), 1);
            chk_disp(rem, poke ? "R9 count unaffected by up/down" : "R7 remaining count");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(running == 1'b0, "R1 running reset", int'(running), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        chk_disp(0, "R1 R11 display reset");

        press(0, HOLD);
        chk(running == 1'b0, "R6 confirm at 000 ignored", int'(running), 0);
        chk_disp(0, "R6 display stays 000");

        press(3, HOLD); setv = 999;
        chk_disp(setv, "R4 down wraps to 999");
        press(2, HOLD); setv = 0;
        chk_disp(setv, "R3 up wraps to 000");

        press(2, DEB - 3);
        chk_disp(setv, "R2 short glitch ignored");
        press(2, 5 * DEB); setv = 1;
        chk_disp(setv, "R2 held press acts once");
        press(2, HOLD); setv = 2;
        chk_disp(setv, "R3 up increments");

        done_cnt = 0;
        run_check(1'b1, 0);
        chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
        repeat (HOLD) @(negedge clk);
        chk_disp(setv, "R9 set value kept after run");

        for (int i = 0; i < 8; i++) press(2, HOLD);
        setv = 10;
        chk_disp(setv, "R3 set to 010");
        run_check(1'b0, 0);
        repeat (HOLD) @(negedge clk);

        done_cnt = 0;
        run_check(1'b0, TICK + 3);
        btn[0] = 1'b0;
        press(1, HOLD); setv = 0;
        chk(running == 1'b0, "R10 init stops run", int'(running), 0);
        chk_disp(0, "R10 init clears to 000");
        repeat (2 * TICK) @(negedge clk);
        chk(done_cnt == 0, "R10 no done after init", done_cnt, 0);

        press(2, HOLD); press(2, HOLD);
        press(1, HOLD);
        chk_disp(0, "R10 init in setting mode");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule